// File: doc/BRIEF.md
# Driver Protection and Fault Supervisor

This block is the fault-handling core of a twelve-channel power driver. The channels are six high-side and six low-side switches. It takes the control word from the serial front end and a slow timebase tick. It also takes the fault comparator flags: per-channel overcurrent, per-channel open-load, undervoltage, overvoltage, thermal prewarning and thermal shutdown. Its outputs are the gate enable of each channel and the status word that the serial front end shifts back to the host.

Each channel has its own overcurrent timer. A control bit selects a long or a short timeout. When the timer expires, that one channel is latched off. If a thermal prewarning is present while a channel is in overcurrent, the channel is cut off at once instead of waiting. A supply fault shuts every channel down after its own delay and releases them as soon as the supply is healthy again, but its flag stays latched. A thermal shutdown holds every channel off and drives the whole status word high until the die has cooled and a status reset has been written. A status reset is a control word loaded with its lowest bit set.

Top module: `drv_fault_sup`

## Requirements
- R1: Control word layout: bit 0 is the status reset, bit 1+i commands channel i, bit 13 low enables open-load probing, bit 14 selects the long timeouts, bit 15 is the software enable. A channel whose overcurrent flag stays high for SC_LONG_TICKS ticks (bit 14 high) or SC_SHORT_TICKS ticks (bit 14 low) is latched off, and status bit 13 goes high.
- R2: If a channel's overcurrent flag drops before its timeout, that channel's timer restarts from zero.
- R3: With the prewarning flag high, an overcurrent channel is latched off at the next clock edge, and status bit 13 is set.
- R4: Loading a control word with bit 0 high clears status bit 13 and releases every channel latched off by overcurrent.
- R5: Overvoltage held for OV_LONG_TICKS ticks (bit 14 high) or OV_SHORT_TICKS ticks (bit 14 low) disables all channels and sets status bit 15. Undervoltage does the same after UV_TICKS ticks, whatever bit 14 is.
- R6: Channels come back in the same cycle that both supply flags go low. Status bit 15 stays high until a status reset is loaded.
- R7: After the shutdown flag is seen high, the status word reads all ones and all channels are off. This holds until the flag is low and a status reset is then loaded.
- R8: Status bit 0 equals the prewarning flag in every cycle without thermal shutdown. It is not latched.
- R9: When control bit 15 is low or the hardware enable pin is low, all channels are off and status bit 14 is high.
- R10: Status bit 1+i shows channel i's open-load flag when control bit 13 is low and channel i is commanded off. Otherwise it shows channel i's enable.
- R11: A channel is enabled only if it is commanded on and none of the following holds: inhibit, an active supply fault, its own overcurrent latch, a thermal latch. After reset, no latch is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWord | input | 16 | Latched control word |
| ctrlLoad | input | 1 | One-cycle pulse when a new control word is latched |
| tick | input | 1 | Timebase tick, one cycle wide |
| ocFlag | input | 12 | Per-channel overcurrent flags |
| olFlag | input | 12 | Per-channel open-load comparator flags |
| uvFlag | input | 1 | Supply undervoltage flag |
| ovFlag | input | 1 | Supply overvoltage flag |
| warnFlag | input | 1 | Thermal prewarning flag |
| hotFlag | input | 1 | Thermal shutdown flag |
| hwEnable | input | 1 | Hardware enable pin, low forces all channels off |
| drvEn | output | 12 | Gated channel enables |
| statusWord | output | 16 | Status word for the serial front end |

## Verification
A vector table runs static control words through the status mapping: inhibit from either source, open-load probing on and off, commanded and uncommanded channels, and the prewarning bit. This separates status bits that come from the open-load flags from status bits that follow the enables. Directed runs hold overcurrent and supply flags for exactly one tick less than the timeout and then for exactly the timeout, under both timer selections. This separates the long and short delays, and separates the fixed undervoltage delay from the selectable overvoltage one. Further runs interrupt an overcurrent flag to show the timer restarts, and pair prewarning with overcurrent for the immediate cutoff. They also issue a status reset with shutdown still present and again after cooling, which shows the two-condition release.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  // Strobes and levels handed from the control side to the datapath
  typedef struct packed {
    logic clearFaults;  // status reset loaded this cycle
    logic longDelay;    // long short-circuit timeout selected
    logic warnCut;      // prewarning present: cut overcurrent channels now
    logic supplyFail;   // supply fault active, all channels off
    logic thermalHold;  // thermal latch set
    logic inhibit;      // software or hardware inhibit
    logic psfBit;       // latched supply-fail status
  } dfs_strobe_t;
endpackage

// File: rtl/dfs_delay_timer.sv
module dfs_delay_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = run && tick && (cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick && !expire) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int TW             = 12,
  parameter int OV_LONG_TICKS  = 480,
  parameter int OV_SHORT_TICKS = 112,
  parameter int UV_TICKS       = 448
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srrReq,
  input  logic        timerSel,
  input  logic        swEnable,
  input  logic        hwEnable,
  input  logic        tick,
  input  logic        uvFlag,
  input  logic        ovFlag,
  input  logic        warnFlag,
  input  logic        hotFlag,
  output dfs_strobe_t strobe
);
  logic          uvExpire, ovExpire;
  logic          supActive, psfLatch, hotLatch;
  logic [TW-1:0] ovLimit;

  assign ovLimit = timerSel ? TW'(OV_LONG_TICKS) : TW'(OV_SHORT_TICKS);

  dfs_delay_timer #(.TW(TW)) u_uvTimer (
    .clk(clk), .rstN(rstN), .run(uvFlag), .tick(tick),
    .limit(TW'(UV_TICKS)), .expire(uvExpire)
  );

  dfs_delay_timer #(.TW(TW)) u_ovTimer (
    .clk(clk), .rstN(rstN), .run(ovFlag), .tick(tick),
    .limit(ovLimit), .expire(ovExpire)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supActive <= 1'b0;
      psfLatch  <= 1'b0;
      hotLatch  <= 1'b0;
    end else begin
      // supply fault: set on expiry, drops once supply is healthy
      if (uvExpire || ovExpire)     supActive <= 1'b1;
      else if (!(uvFlag || ovFlag)) supActive <= 1'b0;
      // supply-fail status: sticky until status reset, set wins
      if (uvExpire || ovExpire) psfLatch <= 1'b1;
      else if (srrReq)          psfLatch <= 1'b0;
      // thermal latch: reset only accepted once the flag is gone
      if (hotFlag)     hotLatch <= 1'b1;
      else if (srrReq) hotLatch <= 1'b0;
    end
  end

  always_comb begin
    strobe.clearFaults = srrReq;
    strobe.longDelay   = timerSel;
    strobe.warnCut     = warnFlag;
    strobe.supplyFail  = supActive && (uvFlag || ovFlag);
    strobe.thermalHold = hotLatch;
    strobe.inhibit     = !swEnable || !hwEnable;
    strobe.psfBit      = psfLatch;
  end
endmodule

// File: rtl/dfs_dpath.sv
module dfs_dpath
  import dfs_pkg::*;
#(
  parameter int NUM_OUT        = 12,
  parameter int TW             = 12,
  parameter int SC_LONG_TICKS  = 3200,
  parameter int SC_SHORT_TICKS = 400,
  localparam int STAT_W        = NUM_OUT + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dfs_strobe_t        strobe,
  input  logic [NUM_OUT-1:0] cmd,
  input  logic               openLoadOff,
  input  logic               tick,
  input  logic [NUM_OUT-1:0] ocFlag,
  input  logic [NUM_OUT-1:0] olFlag,
  output logic [NUM_OUT-1:0] drvEn,
  output logic [STAT_W-1:0]  statusWord
);
  logic [TW-1:0]      scLimit;
  logic [NUM_OUT-1:0] scExpire, scSet, scLatch, chanStat;
  logic               scdBit, globalOff;

  assign scLimit   = strobe.longDelay ? TW'(SC_LONG_TICKS) : TW'(SC_SHORT_TICKS);
  assign globalOff = strobe.inhibit || strobe.supplyFail || strobe.thermalHold;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    dfs_delay_timer #(.TW(TW)) u_scTimer (
      .clk(clk), .rstN(rstN), .run(ocFlag[i]), .tick(tick),
      .limit(scLimit), .expire(scExpire[i])
    );

    assign scSet[i] = scExpire[i] || (strobe.warnCut && ocFlag[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   scLatch[i] <= 1'b0;
      else if (scSet[i])           scLatch[i] <= 1'b1;
      else if (strobe.clearFaults) scLatch[i] <= 1'b0;
    end

    assign drvEn[i]    = cmd[i] && !globalOff && !scLatch[i];
    assign chanStat[i] = (!openLoadOff && !cmd[i]) ? olFlag[i] : drvEn[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   scdBit <= 1'b0;
    else if (|scSet)             scdBit <= 1'b1;
    else if (strobe.clearFaults) scdBit <= 1'b0;
  end

  always_comb begin
    if (strobe.thermalHold) statusWord = '1;
    else statusWord = {strobe.psfBit, strobe.inhibit, scdBit, chanStat, strobe.warnCut};
  end
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
  import dfs_pkg::*;
#(
  parameter int NUM_PAIR       = 6,
  parameter int SC_LONG_TICKS  = 3200,
  parameter int SC_SHORT_TICKS = 400,
  parameter int OV_LONG_TICKS  = 480,
  parameter int OV_SHORT_TICKS = 112,
  parameter int UV_TICKS       = 448,
  localparam int NUM_OUT       = 2 * NUM_PAIR,
  localparam int WORD_W        = NUM_OUT + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  ctrlWord,
  input  logic               ctrlLoad,
  input  logic               tick,
  input  logic [NUM_OUT-1:0] ocFlag,
  input  logic [NUM_OUT-1:0] olFlag,
  input  logic               uvFlag,
  input  logic               ovFlag,
  input  logic               warnFlag,
  input  logic               hotFlag,
  input  logic               hwEnable,
  output logic [NUM_OUT-1:0] drvEn,
  output logic [WORD_W-1:0]  statusWord
);
  localparam int MAX_SC = (SC_LONG_TICKS > SC_SHORT_TICKS) ? SC_LONG_TICKS : SC_SHORT_TICKS;
  localparam int MAX_OV = (OV_LONG_TICKS > OV_SHORT_TICKS) ? OV_LONG_TICKS : OV_SHORT_TICKS;
  localparam int MAX_SV = (MAX_OV > UV_TICKS) ? MAX_OV : UV_TICKS;
  localparam int MAX_T  = (MAX_SC > MAX_SV) ? MAX_SC : MAX_SV;
  localparam int TW     = $clog2(MAX_T + 1);

  localparam int BIT_OLOFF = NUM_OUT + 1;
  localparam int BIT_SEL   = NUM_OUT + 2;
  localparam int BIT_SWEN  = NUM_OUT + 3;

  dfs_strobe_t strobe;

  dfs_ctrl #(
    .TW(TW), .OV_LONG_TICKS(OV_LONG_TICKS),
    .OV_SHORT_TICKS(OV_SHORT_TICKS), .UV_TICKS(UV_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .srrReq(ctrlLoad && ctrlWord[0]),
    .timerSel(ctrlWord[BIT_SEL]),
    .swEnable(ctrlWord[BIT_SWEN]),
    .hwEnable(hwEnable), .tick(tick),
    .uvFlag(uvFlag), .ovFlag(ovFlag),
    .warnFlag(warnFlag), .hotFlag(hotFlag),
    .strobe(strobe)
  );

  dfs_dpath #(
    .NUM_OUT(NUM_OUT), .TW(TW),
    .SC_LONG_TICKS(SC_LONG_TICKS), .SC_SHORT_TICKS(SC_SHORT_TICKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmd(ctrlWord[NUM_OUT:1]),
    .openLoadOff(ctrlWord[BIT_OLOFF]),
    .tick(tick), .ocFlag(ocFlag), .olFlag(olFlag),
    .drvEn(drvEn), .statusWord(statusWord)
  );
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int NUM_OUT = 12,
  localparam int WORD_W = NUM_OUT + 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               srrReq,
  input logic               swEnable,
  input logic [NUM_OUT-1:0] cmd,
  input logic [NUM_OUT-1:0] ocFlag,
  input logic               warnFlag,
  input logic               hotFlag,
  input logic               hwEnable,
  input logic [NUM_OUT-1:0] drvEn,
  input logic [WORD_W-1:0]  statusWord
);
  assert_warn_cut_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warnFlag && (ocFlag != '0)) |=> ((drvEn & $past(ocFlag)) == '0));

  assert_psf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[WORD_W-1] && !srrReq) |=> statusWord[WORD_W-1]);

  assert_thermal_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |=> (statusWord == '1 && drvEn == '0));

  assert_warn_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord != '1) |-> (statusWord[0] == warnFlag));

  assert_inhibit_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!swEnable || !hwEnable) |-> (drvEn == '0 && statusWord[WORD_W-2]));

  assert_cmd_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn & ~cmd) == '0);
endmodule

bind drv_fault_sup dfs_checker #(.NUM_OUT(NUM_OUT)) u_checker (
  .clk(clk), .rstN(rstN),
  .srrReq(ctrlLoad && ctrlWord[0]),
  .swEnable(ctrlWord[WORD_W-1]),
  .cmd(ctrlWord[NUM_OUT:1]),
  .ocFlag(ocFlag), .warnFlag(warnFlag), .hotFlag(hotFlag),
  .hwEnable(hwEnable), .drvEn(drvEn), .statusWord(statusWord)
);

// File: tb/drv_fault_sup_bench.sv
module drv_fault_sup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCL = 8, SCS = 3, OVL = 6, OVS = 2, UVT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ctrlWord = 16'hE000;
  logic        ctrlLoad = 1'b0;
  logic        tick = 1'b1;
  logic [11:0] ocFlag = '0, olFlag = '0;
  logic        uvFlag = 1'b0, ovFlag = 1'b0, warnFlag = 1'b0, hotFlag = 1'b0;
  logic        hwEnable = 1'b1;
  logic [11:0] drvEn;
  logic [15:0] statusWord;
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_fault_sup #(
    .SC_LONG_TICKS(SCL), .SC_SHORT_TICKS(SCS),
    .OV_LONG_TICKS(OVL), .OV_SHORT_TICKS(OVS), .UV_TICKS(UVT)
  ) u_drv_fault_sup (.*);

  // {ctrl, olFlag, hwEnable, warnFlag, expected drvEn, expected status}
  localparam logic [57:0] VEC [0:8] = '{
    {16'hE000, 12'h000, 1'b1, 1'b0, 12'h000, 16'h0000},
    {16'hE006, 12'h000, 1'b1, 1'b0, 12'h003, 16'h0006},
    {16'hC006, 12'hFFF, 1'b1, 1'b0, 12'h003, 16'h1FFE},
    {16'hC000, 12'h005, 1'b1, 1'b0, 12'h000, 16'h000A},
    {16'h6006, 12'h000, 1'b1, 1'b0, 12'h000, 16'h4000},
    {16'hE006, 12'h000, 1'b0, 1'b0, 12'h000, 16'h4000},
    {16'hFFFE, 12'hFFF, 1'b1, 1'b0, 12'hFFF, 16'h1FFE},
    {16'h5FFE, 12'h000, 1'b1, 1'b0, 12'h000, 16'h4000},
    {16'hE000, 12'h000, 1'b1, 1'b1, 12'h000, 16'h0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic srr();
    @(negedge clk);
    ctrlLoad = 1'b1; ctrlWord[0] = 1'b1;
    @(negedge clk);
    ctrlLoad = 1'b0; ctrlWord[0] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    cyc(3); rstN = 1'b1; cyc(2);
    chk("R11 reset enables", 32'(drvEn), 32'h000);
    chk("R11 reset status", 32'(statusWord), 32'h0000);

    // R10 R9 R8 static mapping table
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      {ctrlWord, olFlag, hwEnable, warnFlag} = VEC[k][57:28];
      #2;
      chk($sformatf("R10/R9/R8 vec%0d en", k), 32'(drvEn), 32'(VEC[k][27:16]));
      chk($sformatf("R10/R9/R8 vec%0d stat", k), 32'(statusWord), 32'(VEC[k][15:0]));
    end
    olFlag = '0; hwEnable = 1'b1; warnFlag = 1'b0;

    // R1 long short-circuit delay
    @(negedge clk); ctrlWord = 16'hE006; ocFlag = 12'h001;
    cyc(SCL-1);
    chk("R1 long before expiry", 32'(drvEn), 32'h003);
    cyc(1);
    chk("R1 long at expiry", 32'(drvEn), 32'h002);
    chk("R1 scd bit", 32'(statusWord[13]), 32'h1);
    ocFlag = '0;
    srr();
    chk("R4 reset re-enables", 32'(drvEn), 32'h003);
    chk("R4 scd cleared", 32'(statusWord[13]), 32'h0);

    // R1 short delay
    @(negedge clk); ctrlWord = 16'hA006; ocFlag = 12'h002;
    cyc(SCS-1);
    chk("R1 short before expiry", 32'(drvEn), 32'h003);
    cyc(1);
    chk("R1 short at expiry", 32'(drvEn), 32'h001);
    ocFlag = '0; srr();

    // R2 restart on drop
    @(negedge clk); ctrlWord = 16'hE006; ocFlag = 12'h001;
    cyc(SCL-2); ocFlag = '0;
    cyc(1); ocFlag = 12'h001;
    cyc(SCL-1);
    chk("R2 timer restarted", 32'(drvEn), 32'h003);
    ocFlag = '0; cyc(1);
    chk("R2 no scd", 32'(statusWord[13]), 32'h0);

    // R3 prewarning immediate cut
    @(negedge clk); ctrlWord = 16'hE00E; warnFlag = 1'b1; ocFlag = 12'h004;
    cyc(1);
    chk("R3 cut channel", 32'(drvEn), 32'h003);
    chk("R3 scd bit", 32'(statusWord[13]), 32'h1);
    warnFlag = 1'b0; ocFlag = '0; srr();
    chk("R4 after warn cut", 32'(drvEn), 32'h007);

    // R5 overvoltage long
    @(negedge clk); ctrlWord = 16'hE006; ovFlag = 1'b1;
    cyc(OVL-1);
    chk("R5 ov long before", 32'(drvEn), 32'h003);
    cyc(1);
    chk("R5 ov long off", 32'(drvEn), 32'h000);
    chk("R5 psf set", 32'(statusWord[15]), 32'h1);
    ovFlag = 1'b0; #2;
    chk("R6 immediate recovery", 32'(drvEn), 32'h003);
    cyc(3);
    chk("R6 psf sticky", 32'(statusWord[15]), 32'h1);
    srr();
    chk("R6 psf cleared", 32'(statusWord[15]), 32'h0);

    // R5 overvoltage short
    @(negedge clk); ctrlWord = 16'hA006; ovFlag = 1'b1;
    cyc(OVS-1);
    chk("R5 ov short before", 32'(drvEn), 32'h003);
    cyc(1);
    chk("R5 ov short off", 32'(drvEn), 32'h000);
    ovFlag = 1'b0; srr();

    // R5 undervoltage, fixed delay with long select
    @(negedge clk); ctrlWord = 16'hE006; uvFlag = 1'b1;
    cyc(UVT-1);
    chk("R5 uv before", 32'(drvEn), 32'h003);
    cyc(1);
    chk("R5 uv off", 32'(drvEn), 32'h000);
    uvFlag = 1'b0; srr();

    // R7 thermal shutdown
    @(negedge clk); hotFlag = 1'b1;
    cyc(1);
    chk("R7 status all ones", 32'(statusWord), 32'hFFFF);
    chk("R7 outputs off", 32'(drvEn), 32'h000);
    srr();
    chk("R7 reset while hot", 32'(drvEn), 32'h000);
    hotFlag = 1'b0; cyc(3);
    chk("R7 cooled without reset", 32'(statusWord), 32'hFFFF);
    srr();
    chk("R7 released enables", 32'(drvEn), 32'h003);
    chk("R7 released status", 32'(statusWord), 32'h0006);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule